// File: doc/BRIEF.md
# Frame Readout Handshake Engine

This block sends a stored image frame, one byte at a time, from an asynchronous static RAM to a slower external microcontroller. The two sides share no clock, so they pace each other with a four-phase exchange. The receiver raises a ready-to-receive line. The engine then fetches the next byte from memory, places it on an 8-bit bus and raises data-ready. The receiver lowers ready-to-receive once it has taken the byte, and the engine then drops data-ready and moves to the next address.

A transfer begins on a start pulse, which normally follows the end of an image capture. At that moment the engine captures a base address and a frame length in bytes (a full frame is 680 × 500 = 340,000 bytes). Bytes are read in ascending address order from the base. After the last exchange the engine raises a done flag, which stays high until a clear pulse from the next capture request. Chip enable to the memory is held active at all times. The output enable is pulsed for each read, and the data is latched only after a programmable number of wait cycles.

Top module: `frame_readout`

## Requirements
- R1: After reset, data_rdy_o and done_o are 0, mem_oe_n_o is 1, mem_ce_n_o is 0 and bus_data_o is 0.
- R2: rtr_i passes through SYNC_STAGES flip-flops before use. data_rdy_o never rises while rtr_i is low, and it rises only after a new high level of rtr_i has been synchronised.
- R3: The k-th exchange of a frame (counting from 0) presents the byte stored at address base + k, truncated to ADDR_W bits. The engine latches that byte only after mem_oe_n_o has been low for WAIT_CYC full clock cycles.
- R4: bus_data_o holds the same value for one cycle before data_rdy_o rises and for the whole time data_rdy_o is high. data_rdy_o stays high for as long as the synchronised rtr_i stays high.
- R5: After rtr_i falls, data_rdy_o falls. In the same cycle mem_addr_o advances by exactly one, wrapping modulo 2^ADDR_W.
- R6: When the exchange for byte frame_len − 1 completes, done_o rises. While done_o is high, a high rtr_i produces no data_rdy_o and no memory read.
- R7: done_o stays high until a clear_i pulse returns the engine to idle. A start_i pulse while done_o is high has no effect.
- R8: A start_i pulse during a transfer is ignored. The transfer continues with its original base address and length.
- R9: A start_i with frame_len_i equal to 0 raises done_o on the next clock edge and presents no byte.
- R10: mem_ce_n_o is held at 0 in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Engine clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Capture-finished pulse; begins a transfer when idle |
| clear_i | input | 1 | Capture-request pulse; clears done and returns to idle |
| base_addr_i | input | ADDR_W | First memory address of the frame |
| frame_len_i | input | ADDR_W+1 | Number of bytes to send |
| rtr_i | input | 1 | Receiver ready-to-receive, asynchronous |
| mem_rdata_i | input | DATA_W | Read data from the memory |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_oe_n_o | output | 1 | Memory output enable, active low |
| mem_ce_n_o | output | 1 | Memory chip enable, active low, held at 0 |
| bus_data_o | output | DATA_W | Byte presented to the receiver |
| data_rdy_o | output | 1 | Byte valid on the bus |
| done_o | output | 1 | Whole frame sent |

## Verification
A wrong address counter appears as a wrong byte on the bus at the very next exchange, because each memory byte is a distinct function of its address. A counter that skips or repeats also leaves mem_addr_o off by one when data-ready drops. A wait counter that ends early latches the memory's not-yet-valid value, and that corrupts the first byte of the frame. A state machine that mishandles the handshake shows up within a few cycles. It may raise data-ready without a request, drop it while the request is still high, or change the bus under it. A wrong length comparison moves the done flag one exchange early or late, so it is caught at the end of the frame.

// File: rtl/frame_readout_pkg.sv
package frame_readout_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_AWAIT  = 3'd1,
    ST_FETCH  = 3'd2,
    ST_SETUP  = 3'd3,
    ST_OFFER  = 3'd4,
    ST_FINISH = 3'd5
  } rdo_state_t;

endpackage

// File: rtl/rdo_sync.sv
module rdo_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/rdo_fetch.sv
module rdo_fetch #(
  parameter int ADDR_W   = 21,
  parameter int DATA_W   = 8,
  parameter int WAIT_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              fetch_i,
  input  logic              advance_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              oe_n_o,
  output logic [DATA_W-1:0] data_o,
  output logic              latch_o
);

  localparam int CNT_W = $clog2(WAIT_CYC + 2);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [CNT_W-1:0]  wait_q;

  function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  function automatic logic wait_over(input logic [CNT_W-1:0] c);
    return c == CNT_W'(WAIT_CYC);
  endfunction

  assign latch_o = fetch_i && wait_over(wait_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q <= '0;
    end else if (!fetch_i || latch_o) begin
      wait_q <= '0;
    end else begin
      wait_q <= wait_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (load_i) begin
      addr_q <= base_i;
    end else if (advance_i) begin
      addr_q <= step_addr(addr_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (latch_o) begin
      data_q <= rdata_i;
    end
  end

  assign addr_o = addr_q;
  assign oe_n_o = !fetch_i;
  assign data_o = data_q;

endmodule

// File: rtl/rdo_ctrl.sv
module rdo_ctrl
  import frame_readout_pkg::*;
#(
  parameter int LEN_W = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             clear_i,
  input  logic             rtr_s_i,
  input  logic             latch_i,
  input  logic [LEN_W-1:0] frame_len_i,
  output logic             load_o,
  output logic             fetch_o,
  output logic             advance_o,
  output logic             data_rdy_o,
  output logic             done_o,
  output rdo_state_t       state_o
);

  rdo_state_t       state_q, state_d;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] sent_q;
  logic             last_w;

  function automatic logic final_byte(input logic [LEN_W-1:0] sent,
                                      input logic [LEN_W-1:0] len);
    return (sent + LEN_W'(1)) == len;
  endfunction

  assign last_w    = final_byte(sent_q, len_q);
  assign load_o    = (state_q == ST_IDLE) && start_i;
  assign fetch_o   = (state_q == ST_FETCH);
  assign advance_o = (state_q == ST_OFFER) && !rtr_s_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start_i) state_d = (frame_len_i == '0) ? ST_FINISH : ST_AWAIT;
      ST_AWAIT:  if (rtr_s_i) state_d = ST_FETCH;
      ST_FETCH:  if (latch_i) state_d = ST_SETUP;
      ST_SETUP:  state_d = ST_OFFER;
      ST_OFFER:  if (!rtr_s_i) state_d = last_w ? ST_FINISH : ST_AWAIT;
      ST_FINISH: if (clear_i) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      len_q   <= '0;
      sent_q  <= '0;
    end else begin
      state_q <= state_d;
      if (load_o) begin
        len_q  <= frame_len_i;
        sent_q <= '0;
      end else if (advance_o) begin
        sent_q <= sent_q + LEN_W'(1);
      end
    end
  end

  assign data_rdy_o = (state_q == ST_OFFER);
  assign done_o     = (state_q == ST_FINISH);
  assign state_o    = state_q;

endmodule

// File: rtl/frame_readout.sv
module frame_readout
  import frame_readout_pkg::*;
#(
  parameter int ADDR_W      = 21,
  parameter int DATA_W      = 8,
  parameter int WAIT_CYC    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              clear_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic [ADDR_W:0]   frame_len_i,
  input  logic              rtr_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_oe_n_o,
  output logic              mem_ce_n_o,
  output logic [DATA_W-1:0] bus_data_o,
  output logic              data_rdy_o,
  output logic              done_o
);

  localparam int LEN_W = ADDR_W + 1;

  logic       rtr_s;
  logic       ev_load;
  logic       ev_fetch;
  logic       ev_advance;
  logic       ev_latch;
  rdo_state_t fsm_state;

  rdo_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (rtr_i),
    .sync_o  (rtr_s)
  );

  rdo_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .clear_i     (clear_i),
    .rtr_s_i     (rtr_s),
    .latch_i     (ev_latch),
    .frame_len_i (frame_len_i),
    .load_o      (ev_load),
    .fetch_o     (ev_fetch),
    .advance_o   (ev_advance),
    .data_rdy_o  (data_rdy_o),
    .done_o      (done_o),
    .state_o     (fsm_state)
  );

  rdo_fetch #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .WAIT_CYC (WAIT_CYC)
  ) u_fetch (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (ev_load),
    .base_i    (base_addr_i),
    .fetch_i   (ev_fetch),
    .advance_i (ev_advance),
    .rdata_i   (mem_rdata_i),
    .addr_o    (mem_addr_o),
    .oe_n_o    (mem_oe_n_o),
    .data_o    (bus_data_o),
    .latch_o   (ev_latch)
  );

  assign mem_ce_n_o = 1'b0;

endmodule

// File: rtl/frame_readout_chk.sv
module frame_readout_chk #(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clear_i,
  input logic              rtr_s,
  input logic              ev_latch,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_oe_n_o,
  input logic [DATA_W-1:0] bus_data_o,
  input logic              data_rdy_o,
  input logic              done_o
);

  AST_RDY_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_rdy_o) |-> rtr_s); // R2

  AST_LATCH_UNDER_OE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_latch |-> !mem_oe_n_o && !data_rdy_o); // R3

  AST_BUS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    data_rdy_o |-> $stable(bus_data_o)); // R4

  AST_RDY_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    data_rdy_o && rtr_s |=> data_rdy_o); // R4

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(data_rdy_o) |-> (mem_addr_o - $past(mem_addr_o)) == ADDR_W'(1)); // R5

  AST_DONE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !data_rdy_o && mem_oe_n_o); // R6

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !clear_i |=> done_o); // R7

endmodule

bind frame_readout frame_readout_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .clear_i    (clear_i),
  .rtr_s      (rtr_s),
  .ev_latch   (ev_latch),
  .mem_addr_o (mem_addr_o),
  .mem_oe_n_o (mem_oe_n_o),
  .bus_data_o (bus_data_o),
  .data_rdy_o (data_rdy_o),
  .done_o     (done_o)
);

// File: tb/frame_readout_bench.sv
module frame_readout_bench;

  localparam int AW   = 21;
  localparam int DW   = 8;
  localparam int WAIT = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic          clear_i = 1'b0;
  logic [AW-1:0] base_addr_i = '0;
  logic [AW:0]   frame_len_i = '0;
  logic          rtr_i = 1'b0;
  logic [DW-1:0] mem_rdata_i;
  logic [AW-1:0] mem_addr_o;
  logic          mem_oe_n_o;
  logic          mem_ce_n_o;
  logic [DW-1:0] bus_data_o;
  logic          data_rdy_o;
  logic          done_o;

  int checks = 0;
  int errors = 0;
  int oe_cnt = 0;

  always #10 clk = ~clk;

  frame_readout #(.ADDR_W(AW), .DATA_W(DW), .WAIT_CYC(WAIT), .SYNC_STAGES(2)) u_frame_readout (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .clear_i(clear_i),
    .base_addr_i(base_addr_i), .frame_len_i(frame_len_i), .rtr_i(rtr_i),
    .mem_rdata_i(mem_rdata_i), .mem_addr_o(mem_addr_o), .mem_oe_n_o(mem_oe_n_o),
    .mem_ce_n_o(mem_ce_n_o), .bus_data_o(bus_data_o), .data_rdy_o(data_rdy_o),
    .done_o(done_o)
  );

  function automatic logic [DW-1:0] mem_byte(input logic [AW-1:0] a);
    return (a[7:0] * 8'd29) ^ a[15:8] ^ {3'b000, a[20:16]} ^ 8'h6C;
  endfunction

  // memory model: data valid only once output enable has been low WAIT cycles
  always @(posedge clk) oe_cnt <= mem_oe_n_o ? 0 : oe_cnt + 1;
  assign mem_rdata_i = (!mem_oe_n_o && oe_cnt >= WAIT) ? mem_byte(mem_addr_o)
                                                        : ~mem_byte(mem_addr_o);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1'b1;
    @(negedge clk); sig = 1'b0;
  endtask

  // receiver side of one exchange
  task automatic xfer(input logic [AW-1:0] addr, input int hold, input bit last);
    int n;
    logic [DW-1:0] seen;
    @(negedge clk); rtr_i = 1'b1;
    n = 0;
    while (!data_rdy_o && n < 60) begin @(negedge clk); n++; end
    check(data_rdy_o, "R2 data_rdy after rtr", data_rdy_o, 1);
    check(n >= 2, "R2 synchroniser delay", n, 2);
    check(bus_data_o == mem_byte(addr), "R3 byte at address", bus_data_o, mem_byte(addr));
    check(mem_ce_n_o == 1'b0, "R10 chip enable", mem_ce_n_o, 0);
    seen = bus_data_o;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check(data_rdy_o && bus_data_o == seen, "R4 held while rtr high", bus_data_o, seen);
    end
    rtr_i = 1'b0;
    n = 0;
    while (data_rdy_o && n < 60) begin @(negedge clk); n++; end
    check(!data_rdy_o, "R5 data_rdy drops", data_rdy_o, 0);
    check(mem_addr_o == addr + AW'(1), "R5 address step", mem_addr_o, addr + AW'(1));
    check(done_o == last, "R6 done after last byte", done_o, last);
  endtask

  task automatic run_frame(input logic [AW-1:0] base, input int len, input bit poke);
    logic [AW-1:0] keep;
    base_addr_i = base;
    frame_len_i = (AW+1)'(len);
    pulse(start_i);
    for (int k = 0; k < len; k++) begin
      if (poke && k == 1) begin
        base_addr_i = base ^ AW'(21'h0F0F0);
        frame_len_i = (AW+1)'(1);
        pulse(start_i); // R8: must be ignored
      end
      xfer(base + AW'(k), $urandom_range(0, 4), k == len - 1);
    end
    check(done_o, "R6 done raised", done_o, 1);
    keep = mem_addr_o;
    @(negedge clk); rtr_i = 1'b1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      check(!data_rdy_o && mem_oe_n_o, "R6 quiet after done", data_rdy_o, 0);
    end
    rtr_i = 1'b0;
    base_addr_i = base + AW'(7);
    frame_len_i = (AW+1)'(3);
    pulse(start_i);
    repeat (3) @(negedge clk);
    check(done_o && mem_addr_o == keep, "R7 start ignored while done", mem_addr_o, keep);
    pulse(clear_i);
    check(!done_o, "R7 clear drops done", done_o, 0);
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check(!data_rdy_o && !done_o && mem_oe_n_o && !mem_ce_n_o && bus_data_o == '0,
          "R1 reset state", {data_rdy_o, done_o, mem_oe_n_o, mem_ce_n_o}, 4'b0010);
    rst_n = 1'b1;
    @(negedge clk);
    // R2: no request, no data_rdy
    base_addr_i = AW'(100);
    frame_len_i = (AW+1)'(2);
    pulse(start_i);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check(!data_rdy_o, "R2 idle without rtr", data_rdy_o, 0);
    end
    xfer(AW'(100), 0, 1'b0);
    xfer(AW'(101), 2, 1'b1);
    pulse(clear_i);
    // directed corners
    run_frame(AW'(0), 1, 1'b0);
    run_frame({AW{1'b1}} - AW'(1), 4, 1'b0);      // address wrap
    run_frame(AW'(21'h1234), 6, 1'b1);            // R8 start mid-frame
    // R9 zero length
    base_addr_i = AW'(55);
    frame_len_i = '0;
    pulse(start_i);
    check(done_o && !data_rdy_o, "R9 zero length done", done_o, 1);
    pulse(clear_i);
    // random frames
    for (int f = 0; f < 8; f++) begin
      run_frame(AW'($urandom()), $urandom_range(1, 24), f[0]);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule